// File: doc/BRIEF.md
# Dual-Clock Frame FIFO Pointer Controller

This block steers a large frame store that is written on one clock and read on another. It keeps a write pointer in the write clock domain and a read pointer in the read clock domain. It drives the write strobe and addresses of an external memory array, and the registered output-enable that gates the read data bus. Each side has its own pointer reset, enable and data qualifier. On the write side the qualifier is an input enable. On the read side it is an output enable. A write cycle with the input enable off still moves the pointer, which masks the write and keeps the old contents. A read cycle with the output enable off still moves the pointer, which skips data while the bus is tristated.

A single polarity pin sets the active level of the six controls and the two status flags. Tied high, all eight are active-low. Tied low, all eight are active-high. A pointer reset that arrives while its side is disabled is held and carried out on the next enabled cycle of that side. Each pointer crosses into the other domain in Gray code. The crossed pointer drives two flags. The space flag says the writer can go on without overtaking the reader. The data flag says the writer leads the reader by at least a set lead distance. Neither flag ever blocks a pointer.

The array, the output data register and its tristate buffer sit outside the block. The output data register loads the word at `mem_raddr` on every read-clock edge where `mem_re` is high.

Top module: `fifo_ptr_ctrl`

## Requirements
- R1: Each of w_rst, w_en, w_inen, r_rst, r_en and r_outen counts as asserted when its pin level differs from pol_sel, so pol_sel=1 makes them active-low. Each of in_rdy and out_rdy is driven to its status bit XOR pol_sel, so with pol_sel=1 the flags are active-low.
- R2: On a write-clock edge with write enable and write reset both asserted, the write pointer becomes 0 and mem_we is low for that cycle.
- R3: On a write-clock edge with write enable and input enable asserted and no reset taken, mem_we is high with mem_waddr equal to the current pointer, and mem_waddr then increments by one, wrapping at 2**ADDR_W.
- R4: With write enable asserted and input enable deasserted, mem_we stays low and mem_waddr still increments by one.
- R5: With write enable deasserted, mem_we is low and mem_waddr holds.
- R6: On a read-clock edge with read enable and read reset asserted, the read pointer becomes 0. In the same cycle mem_re is high and mem_raddr is 0, so address 0 is presented. After every read-clock edge, rd_oe equals the output enable sampled at that edge.
- R7: With read enable and output enable asserted, the read pointer advances by one, mem_re is high and mem_raddr is the advanced pointer, so the next location appears on the output.
- R8: With read enable asserted and output enable deasserted, the read pointer still advances and rd_oe goes low after the edge (data skip).
- R9: With read enable deasserted, mem_re is low and the read pointer holds, so the output register keeps its last word.
- R10: A read or write reset seen while its side is disabled is not acted on at once. The pointer is set to 0 on the first later enabled cycle of that side, even if the reset has been released by then.
- R11: The data status is true when the write pointer, as crossed into the read domain, leads the read pointer by at least LEAD locations. It is false when the lead is smaller.
- R12: The space status is false when the write pointer leads the crossed read pointer by 2**ADDR_W or more, and true otherwise. Neither status ever stops a pointer from moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous global reset, active-low, pointers to 0 |
| pol_sel | input | 1 | 1: controls and flags active-low; 0: active-high |
| w_rst | input | 1 | Write pointer reset |
| w_en | input | 1 | Write enable |
| w_inen | input | 1 | Input enable (store qualifier) |
| r_rst | input | 1 | Read pointer reset |
| r_en | input | 1 | Read enable |
| r_outen | input | 1 | Output enable |
| mem_we | output | 1 | Array write strobe, active-high |
| mem_waddr | output | ADDR_W | Array write address |
| mem_re | output | 1 | Output register load strobe, active-high |
| mem_raddr | output | ADDR_W | Address to load into the output register |
| rd_oe | output | 1 | Registered output-bus drive enable, active-high |
| in_rdy | output | 1 | Space-available flag, polarity per pol_sel |
| out_rdy | output | 1 | New-data flag, polarity per pol_sel |

## Verification
The bench builds the controller with ADDR_W=5 and LEAD=4. With 32 locations, the bench reaches a write lead of a full buffer, the wrap of the write address past 31 and the space flag going false within a few dozen cycles. A lead threshold of 4 lets it place the read pointer on either side of the data-flag boundary with short read bursts. Both polarity settings are driven through the same pointers, so the flag inversion is observed on a state that is full and has data waiting.

// File: rtl/fifo_ptr_pkg.sv
package fifo_ptr_pkg;
  // Flops in each clock-domain crossing of a pointer.
  localparam int SYNC_STAGES = 2;

  // A control pin counts as asserted when it differs from the polarity pin.
  function automatic logic pin_active(input logic pin, input logic pol);
    return pin ^ pol;
  endfunction
endpackage

// File: rtl/fifo_side_ptr.sv
module fifo_side_ptr #(
  parameter int PW = 11,
  parameter int AW = 10,
  parameter bit LOOKAHEAD = 1'b0,
  parameter bit STROBE_ON_RESET = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rst_req,
  input  logic          qual,
  output logic [PW-1:0] ptr,
  output logic [AW-1:0] addr,
  output logic          strobe
);
  logic          pend_q;
  logic          take;
  logic [PW-1:0] ptr_nxt;

  // A reset request is taken only on an enabled cycle; otherwise it waits.
  assign take = en & (rst_req | pend_q);

  always_comb begin
    ptr_nxt = ptr;
    if (en) ptr_nxt = take ? '0 : ptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      pend_q <= 1'b0;
    end else begin
      ptr    <= ptr_nxt;
      pend_q <= en ? 1'b0 : (pend_q | rst_req);
    end
  end

  assign strobe = en & qual & (STROBE_ON_RESET | ~take);

  // Write side addresses the current slot; read side fetches the slot it moves to.
  generate
    if (LOOKAHEAD) begin : g_ahead
      assign addr = ptr_nxt[AW-1:0];
    end else begin : g_now
      assign addr = ptr[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/ptr_gray_sync.sv
module ptr_gray_sync
  import fifo_ptr_pkg::*;
#(
  parameter int PW = 11
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_bin,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0] gray_q;
  logic [PW-1:0] stg [SYNC_STAGES];

  // Registered in the source domain so only one bit moves per step.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_q;
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  generate
    for (genvar b = 0; b < PW; b++) begin : g_g2b
      assign dst_bin[b] = ^stg[SYNC_STAGES-1][PW-1:b];
    end
  endgenerate
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import fifo_ptr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEAD   = 192
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              pol_sel,
  input  logic              w_rst,
  input  logic              w_en,
  input  logic              w_inen,
  input  logic              r_rst,
  input  logic              r_en,
  input  logic              r_outen,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              rd_oe,
  output logic              in_rdy,
  output logic              out_rdy
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;
  localparam logic [PW-1:0] LEAD_P  = PW'(LEAD);

  logic          wen_a, wrst_a, wie_a, ren_a, rrst_a, roe_a;
  logic [PW-1:0] wr_ptr, rd_ptr, rd_ptr_w, wr_ptr_r;
  logic [PW-1:0] wdist, rdist;
  logic          space_q, data_q;

  assign wen_a  = pin_active(w_en,    pol_sel);
  assign wrst_a = pin_active(w_rst,   pol_sel);
  assign wie_a  = pin_active(w_inen,  pol_sel);
  assign ren_a  = pin_active(r_en,    pol_sel);
  assign rrst_a = pin_active(r_rst,   pol_sel);
  assign roe_a  = pin_active(r_outen, pol_sel);

  fifo_side_ptr #(.PW(PW), .AW(ADDR_W), .LOOKAHEAD(1'b0), .STROBE_ON_RESET(1'b0)) u_wside (
    .clk(wclk), .rst_n(rst_n), .en(wen_a), .rst_req(wrst_a), .qual(wie_a),
    .ptr(wr_ptr), .addr(mem_waddr), .strobe(mem_we)
  );

  fifo_side_ptr #(.PW(PW), .AW(ADDR_W), .LOOKAHEAD(1'b1), .STROBE_ON_RESET(1'b1)) u_rside (
    .clk(rclk), .rst_n(rst_n), .en(ren_a), .rst_req(rrst_a), .qual(1'b1),
    .ptr(rd_ptr), .addr(mem_raddr), .strobe(mem_re)
  );

  ptr_gray_sync #(.PW(PW)) u_r2w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n), .src_bin(rd_ptr), .dst_bin(rd_ptr_w)
  );

  ptr_gray_sync #(.PW(PW)) u_w2r (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n), .src_bin(wr_ptr), .dst_bin(wr_ptr_r)
  );

  assign wdist = wr_ptr - rd_ptr_w;
  assign rdist = wr_ptr_r - rd_ptr;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) space_q <= 1'b1;
    else        space_q <= (wdist < DEPTH_P);
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      rd_oe  <= 1'b0;
    end else begin
      data_q <= (rdist >= LEAD_P);
      rd_oe  <= roe_a;
    end
  end

  assign in_rdy  = space_q ^ pol_sel;
  assign out_rdy = data_q  ^ pol_sel;
endmodule

// File: rtl/fifo_ptr_ctrl_chk.sv
module fifo_ptr_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              pol_sel,
  input logic              w_rst,
  input logic              w_en,
  input logic              w_inen,
  input logic              r_rst,
  input logic              r_en,
  input logic              r_outen,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              rd_oe,
  input logic [ADDR_W:0]   rd_ptr
);
  logic wen, wrst, wie, ren, rrst, roe;
  assign wen  = w_en    ^ pol_sel;
  assign wrst = w_rst   ^ pol_sel;
  assign wie  = w_inen  ^ pol_sel;
  assign ren  = r_en    ^ pol_sel;
  assign rrst = r_rst   ^ pol_sel;
  assign roe  = r_outen ^ pol_sel;

  assert_wr_reset_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && wrst) |=> (mem_waddr == '0));

  assert_wr_step_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    mem_we |=> (mem_waddr == $past(mem_waddr) + ADDR_W'(1)));

  assert_mask_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && !wie) |-> !mem_we);

  assert_wr_hold_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    !wen |=> $stable(mem_waddr));

  assert_rd_reset_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren && rrst) |=> (rd_ptr == '0));

  assert_oe_on_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    roe |=> rd_oe);

  assert_oe_off_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !roe |=> !rd_oe);

  assert_rd_hold_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    !ren |=> $stable(rd_ptr));

  assert_defer_R10: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ren && rrst) ##1 ren |=> (rd_ptr == '0));
endmodule

bind fifo_ptr_ctrl fifo_ptr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .pol_sel(pol_sel),
  .w_rst(w_rst), .w_en(w_en), .w_inen(w_inen),
  .r_rst(r_rst), .r_en(r_en), .r_outen(r_outen),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .rd_oe(rd_oe), .rd_ptr(rd_ptr)
);

// File: tb/fifo_ptr_ctrl_test.sv
`timescale 1ns/1ps
module fifo_ptr_ctrl_test;
  localparam int AW = 5;
  localparam int LD = 4;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, pol_sel = 1'b0;
  logic w_rst = 1'b0, w_en = 1'b0, w_inen = 1'b0;
  logic r_rst = 1'b0, r_en = 1'b0, r_outen = 1'b0;
  logic mem_we, mem_re, rd_oe, in_rdy, out_rdy;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0] wdata = 8'h00;
  logic [7:0] dout;
  logic [7:0] bmem [1<<AW];
  int tests = 0, fails = 0;

  always #10 wclk = ~wclk;
  initial begin #5; forever #10 rclk = ~rclk; end

  fifo_ptr_ctrl #(.ADDR_W(AW), .LEAD(LD)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .pol_sel(pol_sel),
    .w_rst(w_rst), .w_en(w_en), .w_inen(w_inen),
    .r_rst(r_rst), .r_en(r_en), .r_outen(r_outen),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .rd_oe(rd_oe), .in_rdy(in_rdy), .out_rdy(out_rdy)
  );

  // Array and output register models around the controller.
  always @(posedge wclk) if (mem_we) bmem[mem_waddr] <= wdata;
  always @(posedge rclk) if (mem_re) dout <= bmem[mem_raddr];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input logic r, input logic e, input logic i, input logic [7:0] d);
    @(negedge wclk); w_rst = r; w_en = e; w_inen = i; wdata = d;
    @(posedge wclk); #1;
  endtask

  task automatic rcyc(input logic r, input logic e, input logic o);
    @(negedge rclk); r_rst = r; r_en = e; r_outen = o;
    @(posedge rclk); #1;
  endtask

  // {pol_sel, w_rst, w_en, w_inen, expected mem_we, expected mem_waddr after edge}
  localparam logic [9:0] VEC [12] = '{
    10'b0_0_1_1_1_00001,  // R3 store and step
    10'b0_0_1_0_0_00010,  // R4 mask
    10'b0_0_0_1_0_00010,  // R5 hold
    10'b0_1_0_1_0_00010,  // R10 reset while disabled
    10'b0_0_0_0_0_00010,  // R10 still waiting
    10'b0_0_1_1_0_00000,  // R10 deferred reset taken
    10'b0_0_1_1_1_00001,  // R3
    10'b1_1_0_0_1_00010,  // R1 active-low store
    10'b1_1_0_1_0_00011,  // R1 R4 active-low mask
    10'b1_1_1_0_0_00011,  // R1 R5 active-low disabled
    10'b1_0_0_0_0_00000,  // R1 R2 active-low reset
    10'b0_1_1_1_0_00000   // R2 active-high reset
  };

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #50 rst_n = 1'b1;
    @(negedge wclk);
    check("R2 reset waddr", 32'(mem_waddr), 0);
    check("R6 reset raddr", 32'(mem_raddr), 0);
    check("R6 reset rd_oe", 32'(rd_oe), 0);
    check("R12 reset in_rdy", 32'(in_rdy), 1);
    check("R11 reset out_rdy", 32'(out_rdy), 0);

    for (int k = 0; k < 12; k++) begin
      @(negedge wclk);
      pol_sel = VEC[k][9]; w_rst = VEC[k][8]; w_en = VEC[k][7]; w_inen = VEC[k][6];
      #1 check($sformatf("R1 R2 R3 R4 R5 R10 vec %0d mem_we", k), 32'(mem_we), 32'(VEC[k][5]));
      @(posedge wclk); #1;
      check($sformatf("R1 R2 R3 R4 R5 R10 vec %0d waddr", k), 32'(mem_waddr), 32'(VEC[k][4:0]));
    end

    // Active-high from here; fill 8 words.
    @(negedge wclk); pol_sel = 1'b0; w_rst = 1'b0; w_en = 1'b0; w_inen = 1'b0;
    for (int i = 0; i < 8; i++) wcyc(1'b0, 1'b1, 1'b1, 8'hA0 + 8'(i));
    @(negedge wclk); w_en = 1'b0; w_inen = 1'b0;
    check("R3 waddr after 8 writes", 32'(mem_waddr), 8);

    rcyc(1'b1, 1'b1, 1'b1);
    check("R6 read reset data", 32'(dout), 32'hA0);
    check("R6 rd_oe on", 32'(rd_oe), 1);
    rcyc(1'b0, 1'b1, 1'b1);
    check("R7 read next", 32'(dout), 32'hA1);
    rcyc(1'b0, 1'b1, 1'b0);
    check("R8 skip tristate", 32'(rd_oe), 0);
    rcyc(1'b0, 1'b0, 1'b1);
    check("R9 oe back on while disabled", 32'(rd_oe), 1);
    rcyc(1'b0, 1'b1, 1'b1);
    check("R8 skipped word passed", 32'(dout), 32'hA3);
    rcyc(1'b0, 1'b0, 1'b1);
    check("R9 data held", 32'(dout), 32'hA3);
    rcyc(1'b1, 1'b0, 1'b1);
    check("R10 reset while disabled not taken", 32'(dout), 32'hA3);
    rcyc(1'b0, 1'b1, 1'b1);
    check("R10 deferred read reset", 32'(dout), 32'hA0);
    @(negedge rclk); r_en = 1'b0;
    repeat (6) @(posedge rclk);
    #1 check("R11 lead 8 data flag", 32'(out_rdy), 1);

    for (int i = 0; i < 5; i++) rcyc(1'b0, 1'b1, 1'b1);
    @(negedge rclk); r_en = 1'b0;
    check("R7 burst last word", 32'(dout), 32'hA5);
    repeat (6) @(posedge rclk);
    #1 check("R11 lead 3 below threshold", 32'(out_rdy), 0);
    @(negedge wclk);
    check("R12 space with lead 3", 32'(in_rdy), 1);

    for (int i = 0; i < 29; i++) wcyc(1'b0, 1'b1, 1'b1, 8'(i));
    @(negedge wclk); w_en = 1'b0; w_inen = 1'b0;
    repeat (6) @(posedge wclk);
    #1 check("R12 full clears space", 32'(in_rdy), 0);
    check("R3 waddr wrapped", 32'(mem_waddr), 5);

    // Switch to active-low with all controls idle.
    @(negedge wclk);
    pol_sel = 1'b1; w_rst = 1'b1; w_en = 1'b1; w_inen = 1'b1;
    r_rst = 1'b1; r_en = 1'b1; r_outen = 1'b1;
    #1 check("R1 in_rdy inverted when full", 32'(in_rdy), 1);
    repeat (6) @(posedge rclk);
    #1 check("R1 out_rdy active-low with data", 32'(out_rdy), 0);
    @(negedge wclk); w_en = 1'b0; w_inen = 1'b0;
    #1 check("R12 write not blocked when full", 32'(mem_we), 1);
    @(posedge wclk); #1;
    check("R12 pointer moves when full", 32'(mem_waddr), 6);
    @(negedge wclk); w_en = 1'b1; w_inen = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule